// File: doc/BRIEF.md
# Peripheral Bus Clock Divider

This block derives a slower peripheral bus clock from the system clock. Software sets an integer ratio and an output enable through a single 16-bit register port. The ratio can be any value from 1 to 128. Every change of ratio or enable is covered by a ready handshake. Software writes only while ready is high. Ready then drops and stays low until the divider reaches the end of the output period that is running. At that point the new setting becomes active and ready returns high.

Settings are applied only at a period boundary, so the output never produces a runt pulse when the ratio or the enable changes. For a ratio of 1 the block passes the system clock through a glitch-free gate whose enable is captured on the falling edge. For every other ratio the output is a registered square wave.

Top module: `pbclk_divider`

## Requirements
- R1: After reset the register reads 0x8800: ratio field 0 (divide by 1), ready set, enable set.
- R2: The read word carries the active ratio field minus-one encoded in bits 6:0, the ready flag in bit 11 and the enable in bit 15. All other bits read 0, and on a write the bits other than 6:0 and 15 have no effect.
- R3: A write accepted while ready is high makes ready read 0 from the next clock on.
- R4: A write that arrives while ready is low is ignored. The setting that completes is the one from the earlier accepted write.
- R5: A pending ratio and enable become active only at the end of the current output period, in the same cycle that ready rises. Once ready is high, the read word shows the written field and enable.
- R6: For an even divide ratio N, the output is high for N/2 input cycles and low for N/2 input cycles.
- R7: For an odd divide ratio N of at least 3, the output is high for (N-1)/2 input cycles and low for (N+1)/2 input cycles.
- R8: While the active enable is 0, the output stays low.
- R9: With field value 0 (ratio 1) and enable set, the output follows the input clock: it is high in the first half of each input cycle and low in the second half.
- R10: Every high pulse of the divided output lasts exactly the high phase of the ratio in effect; no shortened pulse occurs around a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the source being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| wr_data | input | 16 | Register write word (bits 6:0 ratio-1, bit 15 enable) |
| rd_data | output | 16 | Register read word (bits 6:0 active ratio-1, bit 11 ready, bit 15 enable) |
| pb_clk | output | 1 | Divided, gated peripheral bus clock |

## Verification
The hardest case to reach from the ports is a second write that lands while ready is low. To be meaningful it must arrive before the period boundary applies the first write. The stimulus first programs a long ratio of 100, so the pending window lasts up to a hundred cycles. It then drives the second write on the clock edge right after the accepted one. Whether or not that edge also closes the period, the second write still sees ready low. Random settings, with random values in the write bits that have no function, then sweep ratios and enables. After each settle the duty is measured on the output pin.

// File: rtl/pbclk_pkg.sv
`timescale 1ns/1ps
package pbclk_pkg;
  localparam int REG_W   = 16;
  localparam int RDY_POS = 11;
  localparam int EN_POS  = 15;
  typedef logic [REG_W-1:0] reg_word_t;
endpackage

// File: rtl/pbclk_ctrl.sv
`timescale 1ns/1ps
// Holds the active and pending settings and runs the ready handshake.
module pbclk_ctrl #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_div,
  input  logic             wr_gate,
  input  logic             period_end,
  output logic [DIV_W-1:0] ratio_q,
  output logic [DIV_W-1:0] ratio_d,
  output logic             en_q,
  output logic             en_d,
  output logic             ready_q,
  output logic [DIV_W-1:0] pend_q
);
  logic             ready_d;
  logic [DIV_W-1:0] pend_d;
  logic             pend_en_q, pend_en_d;

  always_comb begin
    ready_d   = ready_q;
    pend_d    = pend_q;
    pend_en_d = pend_en_q;
    ratio_d   = ratio_q;
    en_d      = en_q;
    if (ready_q) begin
      if (wr_en) begin
        pend_d    = wr_div;
        pend_en_d = wr_gate;
        ready_d   = 1'b0;
      end
    end else if (period_end) begin
      ratio_d = pend_q;
      en_d    = pend_en_q;
      ready_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q   <= '0;
      en_q      <= 1'b1;
      ready_q   <= 1'b1;
      pend_q    <= '0;
      pend_en_q <= 1'b1;
    end else begin
      ratio_q   <= ratio_d;
      en_q      <= en_d;
      ready_q   <= ready_d;
      pend_q    <= pend_d;
      pend_en_q <= pend_en_d;
    end
  end
endmodule

// File: rtl/pbclk_counter.sv
`timescale 1ns/1ps
// Period counter and registered output phase.
module pbclk_counter #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] ratio_q,
  input  logic [DIV_W-1:0] ratio_d,
  input  logic             en_d,
  output logic             period_end,
  output logic             phase_q
);
  localparam logic [DIV_W:0] ONE = (DIV_W+1)'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W:0]   high_len_d;
  logic             phase_d;

  assign period_end = (cnt_q == ratio_q);

  always_comb begin
    cnt_d      = period_end ? '0 : cnt_q + 1'b1;
    high_len_d = ({1'b0, ratio_d} + ONE) >> 1;
    phase_d    = en_d && ({1'b0, cnt_d} < high_len_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end
endmodule

// File: rtl/pbclk_gate.sv
`timescale 1ns/1ps
// Output selection: gated input clock for ratio 1, registered phase otherwise.
module pbclk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic bypass,
  input  logic en_q,
  input  logic phase_q,
  output logic pb_clk
);
  logic gate_q;

  // Gate enable changes only while the input clock is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= en_q;
  end

  assign pb_clk = bypass ? (clk & gate_q) : phase_q;
endmodule

// File: rtl/pbclk_divider.sv
`timescale 1ns/1ps
module pbclk_divider #(
  parameter int DIV_W = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        pb_clk
);
  import pbclk_pkg::*;

  logic [DIV_W-1:0] ratio_q, ratio_d, pend_q;
  logic             en_q, en_d, ready_q;
  logic             period_end, phase_q, bypass;
  logic             unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[EN_POS-1:DIV_W]};

  pbclk_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_div(wr_data[DIV_W-1:0]), .wr_gate(wr_data[EN_POS]),
    .period_end(period_end), .ratio_q(ratio_q), .ratio_d(ratio_d),
    .en_q(en_q), .en_d(en_d), .ready_q(ready_q), .pend_q(pend_q)
  );

  pbclk_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ratio_q(ratio_q), .ratio_d(ratio_d),
    .en_d(en_d), .period_end(period_end), .phase_q(phase_q)
  );

  assign bypass = (ratio_q == '0);

  pbclk_gate u_gate (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .en_q(en_q),
    .phase_q(phase_q), .pb_clk(pb_clk)
  );

  always_comb begin
    rd_data              = '0;
    rd_data[DIV_W-1:0]   = ratio_q;
    rd_data[RDY_POS]     = ready_q;
    rd_data[EN_POS]      = en_q;
  end
endmodule

// File: rtl/pbclk_divider_chk.sv
`timescale 1ns/1ps
module pbclk_divider_chk #(
  parameter int DIV_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             ready_q,
  input logic [DIV_W-1:0] pend_q,
  input logic [DIV_W-1:0] ratio_q,
  input logic             en_q,
  input logic             period_end,
  input logic             phase_q,
  input logic             bypass,
  input logic             pb_clk
);
  localparam logic [DIV_W:0] ONE = (DIV_W+1)'(1);
  logic [DIV_W:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_run <= '0;
    else if (phase_q) hi_run <= hi_run + ONE;
    else              hi_run <= '0;
  end

  assert_ready_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ready_q) |=> !ready_q);

  assert_ignore_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ready_q) |=> $stable(pend_q));

  assert_ratio_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio_q) |-> ($past(period_end) && $rose(ready_q)));

  assert_ready_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(period_end));

  assert_gated_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !bypass) |-> !pb_clk);

  assert_no_runt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phase_q) |-> (hi_run == (({1'b0, ratio_q} + ONE) >> 1)));
endmodule

bind pbclk_divider pbclk_divider_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ready_q(ready_q),
  .pend_q(pend_q), .ratio_q(ratio_q), .en_q(en_q),
  .period_end(period_end), .phase_q(phase_q), .bypass(bypass),
  .pb_clk(pb_clk)
);

// File: tb/test_pbclk_divider.sv
`timescale 1ns/1ps
module test_pbclk_divider;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        pb_clk;

  int n_chk  = 0;
  int n_fail = 0;

  pbclk_divider i_pbclk_divider (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pb_clk(pb_clk)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int div, input bit en, input bit rdy);
    logic [15:0] w;
    w = '0;
    w[6:0] = div[6:0];
    w[11]  = rdy;
    w[15]  = en;
    return w;
  endfunction

  task automatic sample(output bit v);
    @(posedge clk); #1;
    v = pb_clk;
  endtask

  task automatic write_word(input logic [15:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk); #1;
      if (rd_data[11]) break;
    end
  endtask

  task automatic measure(input int n, input bit en);
    bit v, prev;
    int h, l, ones;
    if (!en) begin
      ones = 0;
      for (int i = 0; i < 2*n + 8; i++) begin sample(v); ones += v; end
      check(ones == 0, "R8 disabled output", ones, 0);
    end else if (n == 1) begin
      ones = 0;
      for (int i = 0; i < 8; i++) begin
        @(posedge clk); #1; ones += pb_clk;
        @(negedge clk); #1; ones += (pb_clk ? 0 : 1);
      end
      check(ones == 16, "R9 pass-through", ones, 16);
    end else begin
      sample(prev);
      for (int i = 0; i < 400; i++) begin
        sample(v);
        if (!prev && v) break;
        prev = v;
      end
      h = 1;
      for (int i = 0; i < 300; i++) begin sample(v); if (!v) break; h++; end
      l = 1;
      for (int i = 0; i < 300; i++) begin sample(v); if (v) break; l++; end
      if (n % 2 == 0) begin
        check(h == n/2, "R6 even high", h, n/2);
        check(l == n/2, "R6 even low", l, n/2);
      end else begin
        check(h == n/2, "R7 odd high R10", h, n/2);
        check(l == n - n/2, "R7 odd low", l, n - n/2);
      end
    end
  endtask

  task automatic configure(input int div, input bit en, input logic [15:0] junk);
    logic [15:0] w;
    w = junk;
    w[6:0] = div[6:0];
    w[15]  = en;
    write_word(w);
    check(rd_data[11] == 1'b0, "R3 ready low after write", rd_data[11], 0);
    wait_ready();
    check(rd_data == exp_word(div, en, 1'b1), "R5 R2 readback", rd_data,
          exp_word(div, en, 1'b1));
    measure(div + 1, en);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(rd_data == 16'h8800, "R1 reset word", rd_data, 16'h8800);
    measure(1, 1'b1);

    configure(1,   1'b1, 16'h0000);
    configure(2,   1'b1, 16'h0000);
    configure(0,   1'b1, 16'h0000);
    configure(0,   1'b0, 16'h0000);
    configure(127, 1'b1, 16'h0000);
    configure(126, 1'b1, 16'h0000);
    configure(5,   1'b0, 16'h7f80);
    configure(3,   1'b1, 16'h7f80);

    // R4: second write while ready is low must be dropped.
    configure(99, 1'b1, 16'h0000);
    write_word(exp_word(5, 1'b1, 1'b0));
    check(rd_data[11] == 1'b0, "R3 ready low before ignored write", rd_data[11], 0);
    wr_en = 1'b1; wr_data = exp_word(9, 1'b1, 1'b0);
    @(negedge clk); wr_en = 1'b0;
    wait_ready();
    check(rd_data == exp_word(5, 1'b1, 1'b1), "R4 ignored write", rd_data,
          exp_word(5, 1'b1, 1'b1));
    measure(6, 1'b1);

    for (int k = 0; k < 12; k++) begin
      int div;
      bit en;
      div = $urandom_range(0, 127);
      en  = ($urandom_range(0, 3) != 0);
      configure(div, en, 16'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule